// File: doc/BRIEF.md
# Synchronous Pipelined Burst SRAM

A synthesizable behavioural model of a small synchronous static RAM with a 32-bit word split into four byte lanes. Every address, write-data and control input is captured in a register on the rising clock edge. The cycle after capture is the access cycle: the captured controls are decoded, the array is written at the end of that cycle, or the addressed word is read and loaded into an output register. Read data therefore drives the bus one edge later than it would in a flow-through part.

An access is opened by one of two active-low start strobes. The processor strobe always reads. The controller strobe reads or writes according to the write controls. Once opened, a burst continues on its own: a 2-bit counter steps through an aligned group of four words in linear or interleaved order while the advance input is low, and holds the current word while it is high. A start strobe seen while the three chip enables are not all active deselects the device, and the output stops driving after one edge. The output-enable input gates the bus drive combinationally. The bus appears as a data word plus a drive-enable flag, which a pad ring turns into a three-state driver.

Top module: `burst_sram`

## Requirements
- R1: While reset is held, and until the first start strobe after reset, `rdata_oe` is 0. The reset input is asserted asynchronously and released through a two-stage synchronizer.
- R2: A read whose inputs are captured at clock edge k drives `rdata_oe`=1 with the addressed word on `rdata` after edge k+1, and not after edge k.
- R3: In a write, byte lane i (bits 8i+7..8i of `wdata`, i = 0..3) is written only when `lane_wr_n`=0 and `lane_sel_n[i]`=0. An access with `lane_wr_n`=1 and `all_wr_n`=1 is a read, whatever `lane_sel_n` holds.
- R4: `all_wr_n`=0 writes all four lanes, whatever `lane_wr_n` and `lane_sel_n` hold.
- R5: `start_cpu_n`=0 with the chip enabled opens an access at `addr` that is always a read, even when write controls are active. It takes priority over `start_ctl_n`.
- R6: `start_ctl_n`=0 (with `start_cpu_n`=1) and the chip enabled opens an access at `addr`. The access is a write when write controls are active and a read otherwise.
- R7: With both strobes high and a burst open, `step_n`=0 moves to the next burst word and `step_n`=1 repeats the current word. Write controls in such a cycle write that word. The counter wraps modulo 4, and address bits above the low two never change inside a burst.
- R8: With `order_il`=0 captured at burst start and base low bits b, the burst visits low bits b, b+1, b+2, b+3 (mod 4).
- R9: With `order_il`=1 captured at burst start, the burst visits low bits b^0, b^1, b^2, b^3. Changing `order_il` during the burst has no effect.
- R10: The chip is enabled only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A start strobe while it is not enabled deselects: `rdata_oe` is 0 after the next edge, and continuation cycles read and write nothing until a new access opens.
- R11: `oe_n`=1 forces `rdata_oe` to 0 in the same cycle, without registering, and leaves the read pipeline unchanged.
- R12: A write access does not drive the bus: `rdata_oe` is 0 after the edge that ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, captured at the start of an access |
| wdata | input | 32 | Write data, four byte lanes |
| start_cpu_n | input | 1 | Processor start strobe, always reads, active low |
| start_ctl_n | input | 1 | Controller start strobe, reads or writes, active low |
| step_n | input | 1 | Burst advance, active low |
| lane_wr_n | input | 1 | Byte-write qualifier, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| all_wr_n | input | 1 | Write all lanes, active low |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| order_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Output enable, active low, not registered |
| rdata | output | 32 | Read data, zero while not driving |
| rdata_oe | output | 1 | Bus drive enable |

## Verification
The bench checks the one-edge read latency. A design that skipped the output register, or added a second one, would show data a cycle early or late. Byte-masked writes use patterns whose unselected lanes must stay unchanged; a wrong lane decode, or a global write that still obeys the lane selects, would leave stale or corrupted bytes. Bursts are run in both orders from a non-zero base, through the wrap and a hold cycle, and the order input is toggled mid-burst. Deselect is driven through each of the three enables, followed by write-active continuation cycles, so a device that kept bursting would drive the bus or overwrite a word that is read back later.

// File: rtl/bsram_pkg.sv
`timescale 1ns/1ps
package bsram_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BURST_W = 2;

  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [WORD_W-1:0] word_t;

  // Captured controls, all converted to active high.
  typedef struct packed {
    logic       req_cpu;
    logic       req_ctl;
    logic       step;
    logic       all_wr;
    logic       lane_en;
    lane_mask_t lane_sel;
    logic       chip_ok;
    logic       order_il;
  } ctl_t;

  // Low address bits of a burst word: linear adds, interleaved xors.
  function automatic logic [BURST_W-1:0] burst_low(
    input logic [BURST_W-1:0] base,
    input logic [BURST_W-1:0] cnt,
    input logic               il
  );
    return il ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/bsram_rst_sync.sv
`timescale 1ns/1ps
module bsram_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_out_n = sync_q[1];
endmodule

// File: rtl/bsram_in_regs.sv
`timescale 1ns/1ps
module bsram_in_regs
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  word_t            wdata,
  input  logic             start_cpu_n,
  input  logic             start_ctl_n,
  input  logic             step_n,
  input  logic             lane_wr_n,
  input  lane_mask_t       lane_sel_n,
  input  logic             all_wr_n,
  input  logic             ce_a_n,
  input  logic             ce_b,
  input  logic             ce_c_n,
  input  logic             order_il,
  output logic [AW-1:0]    addr_q,
  output word_t            wdata_q,
  output ctl_t             ctl_q
);
  ctl_t ctl_d;

  always_comb begin
    ctl_d.req_cpu  = ~start_cpu_n;
    ctl_d.req_ctl  = ~start_ctl_n;
    ctl_d.step     = ~step_n;
    ctl_d.all_wr   = ~all_wr_n;
    ctl_d.lane_en  = ~lane_wr_n;
    ctl_d.lane_sel = ~lane_sel_n;
    ctl_d.chip_ok  = ~ce_a_n & ce_b & ~ce_c_n;
    ctl_d.order_il = order_il;
  end

  // Controls reset to inactive; address and data need no reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  always_ff @(posedge clk) begin
    addr_q  <= addr;
    wdata_q <= wdata;
  end
endmodule

// File: rtl/bsram_ctrl.sv
`timescale 1ns/1ps
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_q,
  input  ctl_t          ctl_q,
  output logic          acc_valid,
  output logic [AW-1:0] acc_addr,
  output lane_mask_t    wr_mask,
  output logic          burst_cont
);
  localparam int GRP_LSB = BURST_W;

  logic               active_q, active_d;
  logic               order_q;
  logic [BURST_W-1:0] cnt_q, cnt_d, cur_cnt;
  logic [AW-1:0]      base_q;
  logic               cpu_go, ctl_go, start, desel;
  logic               load_en, cnt_en;
  lane_mask_t         req_mask;

  // Next-state and access decode.
  always_comb begin
    cpu_go     = ctl_q.req_cpu & ctl_q.chip_ok;
    ctl_go     = ctl_q.req_ctl & ctl_q.chip_ok & ~ctl_q.req_cpu;
    start      = cpu_go | ctl_go;
    desel      = (ctl_q.req_cpu | ctl_q.req_ctl) & ~ctl_q.chip_ok;
    burst_cont = ~(ctl_q.req_cpu | ctl_q.req_ctl) & active_q;

    if (ctl_q.all_wr)       req_mask = '1;
    else if (ctl_q.lane_en) req_mask = ctl_q.lane_sel;
    else                    req_mask = '0;

    load_en = start;
    cnt_en  = start | (burst_cont & ctl_q.step);
    cnt_d   = start ? '0 : cnt_q + 1'b1;

    if (start)      active_d = 1'b1;
    else if (desel) active_d = 1'b0;
    else            active_d = active_q;

    if (start)                         cur_cnt = '0;
    else if (burst_cont & ctl_q.step)  cur_cnt = cnt_q + 1'b1;
    else                               cur_cnt = cnt_q;

    acc_valid = start | burst_cont;
    if (start)
      acc_addr = addr_q;
    else
      acc_addr = {base_q[AW-1:GRP_LSB], burst_low(base_q[GRP_LSB-1:0], cur_cnt, order_q)};

    wr_mask = (acc_valid & ~cpu_go) ? req_mask : '0;
  end

  // State registers with explicit enables.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      order_q  <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      if (load_en) order_q <= ctl_q.order_il;
      if (cnt_en)  cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) base_q <= addr_q;
  end
endmodule

// File: rtl/bsram_array.sv
`timescale 1ns/1ps
module bsram_array
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic [AW-1:0] acc_addr,
  input  lane_mask_t    wr_mask,
  input  word_t         wdata_q,
  output word_t         rd_word
);
  localparam int DEPTH = 1 << AW;

  // One storage column per byte lane, each with its own write strobe.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_mask[g]) mem[acc_addr] <= wdata_q[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = mem[acc_addr];
  end
endmodule

// File: rtl/bsram_rd_pipe.sv
`timescale 1ns/1ps
module bsram_rd_pipe
  import bsram_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t rd_word,
  input  logic  oe_n,
  output word_t rdata,
  output logic  rdata_oe
);
  logic  vld_q;
  word_t data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= load;
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= rd_word;
  end

  assign rdata_oe = vld_q & ~oe_n;
  assign rdata    = rdata_oe ? data_q : '0;
endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          start_cpu_n,
  input  logic          start_ctl_n,
  input  logic          step_n,
  input  logic          lane_wr_n,
  input  logic [3:0]    lane_sel_n,
  input  logic          all_wr_n,
  input  logic          ce_a_n,
  input  logic          ce_b,
  input  logic          ce_c_n,
  input  logic          order_il,
  input  logic          oe_n,
  output logic [31:0]   rdata,
  output logic          rdata_oe
);
  logic          rst_sync_n;
  logic [AW-1:0] addr_q;
  word_t         wdata_q;
  ctl_t          ctl_q;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  lane_mask_t    wr_mask;
  logic          burst_cont;
  word_t         rd_word;
  logic          acc_rd;

  bsram_rst_sync u_rst (
    .clk      (clk),
    .rst_in_n (rst_n),
    .rst_out_n(rst_sync_n)
  );

  bsram_in_regs #(.AW(AW)) u_in (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .addr       (addr),
    .wdata      (wdata),
    .start_cpu_n(start_cpu_n),
    .start_ctl_n(start_ctl_n),
    .step_n     (step_n),
    .lane_wr_n  (lane_wr_n),
    .lane_sel_n (lane_sel_n),
    .all_wr_n   (all_wr_n),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .order_il   (order_il),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .ctl_q      (ctl_q)
  );

  bsram_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .addr_q    (addr_q),
    .ctl_q     (ctl_q),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .wr_mask   (wr_mask),
    .burst_cont(burst_cont)
  );

  bsram_array #(.AW(AW)) u_mem (
    .clk     (clk),
    .acc_addr(acc_addr),
    .wr_mask (wr_mask),
    .wdata_q (wdata_q),
    .rd_word (rd_word)
  );

  assign acc_rd = acc_valid & (wr_mask == '0);

  bsram_rd_pipe u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (acc_rd),
    .rd_word (rd_word),
    .oe_n    (oe_n),
    .rdata   (rdata),
    .rdata_oe(rdata_oe)
  );
endmodule

// File: rtl/bsram_chk.sv
`timescale 1ns/1ps
module bsram_chk
  import bsram_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_cpu_n,
  input logic          start_ctl_n,
  input logic          ce_a_n,
  input logic          ce_b,
  input logic          ce_c_n,
  input logic          rdata_oe,
  input logic          q_req_cpu,
  input logic          q_chip_ok,
  input logic          q_all_wr,
  input logic          q_lane_en,
  input logic          q_step,
  input logic          acc_valid,
  input logic [AW-1:0] acc_addr,
  input lane_mask_t    wr_mask,
  input logic          burst_cont
);
  // R1: the bus is idle when reset is released.
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rdata_oe);

  // R3: no write controls, no lane written.
  assert_no_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_all_wr && !q_lane_en) |-> (wr_mask == '0));

  // R4: global write covers every lane.
  assert_all_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (q_all_wr && acc_valid && !q_req_cpu) |-> (wr_mask == '1));

  // R5: processor start is always a read access.
  assert_cpu_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_req_cpu && q_chip_ok) |-> (acc_valid && wr_mask == '0));

  // R7: a held burst repeats the same word.
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_cont && !q_step) |-> (acc_addr == $past(acc_addr)));

  // R7: a burst stays inside its aligned group of four.
  assert_group_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cont |-> (acc_addr[AW-1:BURST_W] == $past(acc_addr[AW-1:BURST_W])));

  // R10: a strobe with the chip disabled stops the bus after one edge.
  assert_desel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((!start_cpu_n || !start_ctl_n) && !(!ce_a_n && ce_b && !ce_c_n)) |=> ##1 !rdata_oe);

  // R12: a write leaves the bus undriven.
  assert_write_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && wr_mask != '0) |=> !rdata_oe);
endmodule

bind burst_sram bsram_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start_cpu_n(start_cpu_n),
  .start_ctl_n(start_ctl_n),
  .ce_a_n     (ce_a_n),
  .ce_b       (ce_b),
  .ce_c_n     (ce_c_n),
  .rdata_oe   (rdata_oe),
  .q_req_cpu  (ctl_q.req_cpu),
  .q_chip_ok  (ctl_q.chip_ok),
  .q_all_wr   (ctl_q.all_wr),
  .q_lane_en  (ctl_q.lane_en),
  .q_step     (ctl_q.step),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .wr_mask    (wr_mask),
  .burst_cont (burst_cont)
);

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          start_cpu_n, start_ctl_n, step_n, lane_wr_n, all_wr_n;
  logic [3:0]    lane_sel_n;
  logic          ce_a_n, ce_b, ce_c_n, order_il, oe_n;
  logic [31:0]   rdata;
  logic          rdata_oe;

  logic [31:0]   ref_mem [DEPTH];
  int            n_checks = 0;
  int            n_fail   = 0;
  bit            done     = 1'b0;

  bit            pend_chk = 1'b0;
  bit            pend_oe;
  logic [31:0]   pend_d;
  string         pend_tag;

  always #10 clk = ~clk;

  burst_sram #(.AW(AW)) u_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .step_n(step_n),
    .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .all_wr_n(all_wr_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .order_il(order_il),
    .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic report(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle of inputs (active-high arguments).
  task automatic apply(input bit cpu, input bit ctl, input bit step, input bit len,
                       input logic [3:0] lanes, input bit all,
                       input logic [AW-1:0] a, input logic [31:0] d);
    start_cpu_n = !cpu; start_ctl_n = !ctl; step_n = !step;
    lane_wr_n = !len; lane_sel_n = ~lanes; all_wr_n = !all;
    addr = a; wdata = d;
  endtask

  task automatic idle(input bit step);
    apply(0, 0, step, 0, 4'h0, 0, '0, '0);
  endtask

  // Advance one cycle; check the op driven one cycle earlier; queue this op's expectation.
  task automatic tk(input bit chk, input bit oe, input logic [31:0] d, input string tag);
    @(negedge clk);
    if (pend_chk) begin
      report(pend_tag, "oe", {31'd0, rdata_oe}, {31'd0, pend_oe & !oe_n});
      if (pend_oe && !oe_n) report(pend_tag, "data", rdata, pend_d);
    end
    pend_chk = chk; pend_oe = oe; pend_d = d; pend_tag = tag;
  endtask

  function automatic logic [AW-1:0] ea(input logic [AW-1:0] b, input int k, input bit il);
    logic [1:0] lo;
    lo = il ? (b[1:0] ^ 2'(k)) : (b[1:0] + 2'(k));
    return {b[AW-1:2], lo};
  endfunction

  task automatic stop();
    ce_b = 1'b0;
    apply(0, 1, 0, 0, 4'h0, 0, '0, '0);
    tk(1, 0, '0, "R10");
    ce_b = 1'b1;
    idle(1);
    tk(1, 0, '0, "R10");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    apply(1, 0, 0, 0, 4'h0, 0, a, '0);
    tk(1, 1, ref_mem[a], tag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle(0);
    repeat (3) @(negedge clk);
    report("R1", "oe in reset", {31'd0, rdata_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      idle(1);
      tk(1, 0, '0, "R1");
    end
  endtask

  task automatic t_fill();
    for (int a = 0; a < 24; a++) begin
      logic [31:0] v;
      v = 32'hA5000000 ^ (32'(a) * 32'h01030507);
      apply(0, 1, 0, 1, 4'hF, 0, AW'(a), v);
      tk(1, 0, '0, "R12");
      ref_mem[a] = v;
    end
    stop();
  endtask

  task automatic t_latency();
    rd(5, "R2");
    idle(0);
    tk(1, 1, ref_mem[5], "R7");
    stop();
  endtask

  task automatic t_cpu_read();
    apply(1, 1, 0, 1, 4'hF, 1, 7, 32'hDEADBEEF);
    tk(1, 1, ref_mem[7], "R5");
    stop();
    rd(7, "R5");
    stop();
  endtask

  task automatic t_lanes();
    apply(0, 1, 0, 1, 4'b0101, 0, 8, 32'h11223344);
    tk(1, 0, '0, "R12");
    ref_mem[8] = (ref_mem[8] & 32'hFF00FF00) | (32'h11223344 & 32'h00FF00FF);
    apply(0, 1, 0, 0, 4'hF, 0, 9, 32'h55667788);
    tk(1, 1, ref_mem[9], "R3");
    apply(0, 1, 0, 1, 4'h0, 0, 9, 32'h99AABBCC);
    tk(1, 1, ref_mem[9], "R6");
    rd(8, "R3");
    rd(9, "R3");
    stop();
  endtask

  task automatic t_global();
    apply(0, 1, 0, 0, 4'b0001, 1, 10, 32'hCAFEF00D);
    tk(1, 0, '0, "R4");
    ref_mem[10] = 32'hCAFEF00D;
    apply(0, 1, 0, 1, 4'h0, 1, 11, 32'h0BADC0DE);
    tk(1, 0, '0, "R4");
    ref_mem[11] = 32'h0BADC0DE;
    rd(10, "R4");
    rd(11, "R4");
    stop();
  endtask

  task automatic t_burst_linear();
    order_il = 1'b0;
    apply(0, 1, 0, 0, 4'h0, 0, 13, '0);
    tk(1, 1, ref_mem[13], "R8");
    for (int k = 1; k < 4; k++) begin
      idle(1);
      tk(1, 1, ref_mem[ea(13, k, 0)], "R8");
    end
    idle(1);
    tk(1, 1, ref_mem[13], "R7");
    idle(0);
    tk(1, 1, ref_mem[13], "R7");
    stop();
  endtask

  task automatic t_burst_il();
    order_il = 1'b1;
    apply(0, 1, 0, 0, 4'h0, 0, 14, '0);
    tk(1, 1, ref_mem[14], "R9");
    order_il = 1'b0;
    for (int k = 1; k < 4; k++) begin
      idle(1);
      tk(1, 1, ref_mem[ea(14, k, 1)], "R9");
    end
    stop();
  endtask

  task automatic t_burst_write();
    order_il = 1'b0;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] v;
      v = 32'h0F0F0000 + 32'(k * 17);
      apply(k == 0 ? 1'b0 : 1'b0, k == 0, k != 0, 1, 4'hF, 0, 18, v);
      tk(1, 0, '0, "R12");
      ref_mem[ea(18, k, 0)] = v;
    end
    stop();
    apply(0, 1, 0, 0, 4'h0, 0, 18, '0);
    tk(1, 1, ref_mem[18], "R7");
    for (int k = 1; k < 4; k++) begin
      idle(1);
      tk(1, 1, ref_mem[ea(18, k, 0)], "R7");
    end
    stop();
  endtask

  task automatic t_deselect();
    apply(0, 1, 0, 0, 4'h0, 0, 16, '0);
    tk(1, 1, ref_mem[16], "R8");
    ce_a_n = 1'b1;
    apply(1, 0, 0, 0, 4'h0, 0, 16, '0);
    tk(1, 0, '0, "R10");
    ce_a_n = 1'b0;
    for (int i = 0; i < 2; i++) begin
      apply(0, 0, i == 1, 0, 4'h0, 1, 16, 32'hBAD0BAD0);
      tk(1, 0, '0, "R10");
    end
    rd(16, "R10");
    rd(17, "R10");
    ce_c_n = 1'b1;
    apply(0, 1, 0, 0, 4'h0, 0, 0, '0);
    tk(1, 0, '0, "R10");
    ce_c_n = 1'b0;
    idle(1);
    tk(1, 0, '0, "R10");
    stop();
  endtask

  task automatic t_oe();
    rd(3, "R11");
    oe_n = 1'b1;
    idle(0);
    tk(1, 1, ref_mem[3], "R11");
    oe_n = 1'b0;
    idle(0);
    tk(1, 1, ref_mem[3], "R11");
    stop();
  endtask

  initial begin
    rst_n = 1'b0;
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    order_il = 1'b0; oe_n = 1'b0;
    idle(0);
    t_reset();
    t_fill();
    t_latency();
    t_cpu_read();
    t_lanes();
    t_global();
    t_burst_linear();
    t_burst_il();
    t_burst_write();
    t_deselect();
    t_oe();
    idle(0);
    tk(0, 0, '0, "none");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule